// File: doc/BRIEF.md
# Two-Wire Serial Clock and Battery-RAM Slave

This block is the device side of a small clock chip that a host reaches by toggling bits in one control byte. Each host write to that byte is presented on a write strobe. Bit 0 of the byte selects the device. Bit 1 is the serial clock and bit 2 is the serial data line. Every high-to-low step of the clock bit moves the transfer on by one phase. The first eight phases clock in a command byte, most significant bit first, and the next eight carry a data byte.

The upper bits of the command choose the action. Read commands replace the data bit of the stored control byte with one bit of the addressed byte, so the host sees it when it reads the control byte back. Those bits are also gathered in a read-back shift register. The readable bytes are a 32-byte battery RAM, a status byte, a control byte and six BCD time-of-day registers. Write commands take effect on the sixteenth falling edge. A write to the control byte can also clear the alarm status and the interrupt. The time registers are loaded from a side port; this block does no calendar arithmetic.

Top module: `rtcser_top`

## Requirements
- R1: After a synchronous reset the stored control byte reads 0x00, the interrupt is low, the read-back shift register is 0x00 and the status byte is 0x90.
- R2: Command and data bits are taken only when the clock bit (bit 1) goes from 1 in the stored byte to 0 in the new byte while select (bit 0) is 1. Writes that keep the clock bit steady do not advance the transfer.
- R3: Phases 0-7 shift the command in MSB first. Command 0x80-0x9F stores the 8 data bits into RAM byte (command - 0x80) at the sixteenth falling edge, and command 0x00-0x1F reads RAM byte (command) back.
- R4: During phases 8-15 of any read command, bit (15 - phase) of the selected byte replaces bit 2 of the stored control byte in the same clock. That bit is also shifted into the read-back register.
- R5: Command 0x30 reads the status byte.
- R6: Command 0xB1 writes the control byte at the sixteenth edge, and command 0x31 reads it back.
- R7: Commands 0x20-0x25 read the time registers in order: seconds, minutes, hours, day, month, year. Each is loaded by a pulse on the load input with an index of 0-5. Commands 0x26-0x2F read 0x00.
- R8: An alarm pulse sets status bit 3 and raises the interrupt. A 0xB1 write with bit 2 set clears status bits 4 and 3 and drops the interrupt. A 0xB1 write with bit 2 clear leaves both unchanged.
- R9: When an alarm pulse and a clearing 0xB1 write fall in the same clock, status bit 4 is cleared while bit 3 and the interrupt stay set.
- R10: A write with select at 0 abandons any transfer without committing it. The next falling edge with select at 1 starts again at phase 0.
- R11: After the sixteenth edge the block is idle, so a following falling edge starts a new command without deselecting first.
- R12: During the data phases of a non-read command, bit 2 keeps the host's value and the read-back register is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Host write strobe for the control byte |
| ctl_wdata | input | 8 | Control byte written by host (bit0 select, bit1 clock, bit2 data) |
| ctl_rdata | output | 8 | Stored control byte, bit 2 driven by the device on reads |
| tm_ld | input | 1 | Load strobe for one time register |
| tm_idx | input | 3 | Time register index (0 seconds .. 5 year) |
| tm_bcd | input | 8 | BCD value to load |
| alarm_evt | input | 1 | Alarm event pulse |
| rtc_irq | output | 1 | Interrupt output |
| rd_bits | output | 8 | Shift register of every bit returned to the host |

## Verification
An alarm pulse and a clearing control write can land on the same clock edge, and they act on the same status bits and interrupt flag. The bench raises the alarm input together with the last falling-clock write of a 0xB1 transfer that carries bit 2. It then requires the interrupt to stay high and a following status read to return 0x88: bit 4 has gone and bit 3 has been set again. A behavioural model updated on every edge is compared with the control byte, the interrupt and the read-back register on every cycle, so an ordering error at that edge shows up at once.

// File: rtl/rtcser_pkg.sv
package rtcser_pkg;

  localparam logic [7:0] CMD_STAT_RD = 8'h30;
  localparam logic [7:0] CMD_CTRL_RD = 8'h31;
  localparam logic [7:0] CMD_CTRL_WR = 8'hB1;
  localparam logic [7:0] STAT_CLR_MASK = 8'h18;
  localparam logic [7:0] STAT_ALARM    = 8'h08;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_RAM,
    SRC_TIME,
    SRC_STAT,
    SRC_CTRL
  } src_e;

  function automatic src_e decode_src(input logic [7:0] c);
    if (c[7:5] == 3'b000)      return SRC_RAM;
    else if (c[7:4] == 4'h2)   return SRC_TIME;
    else if (c == CMD_STAT_RD) return SRC_STAT;
    else if (c == CMD_CTRL_RD) return SRC_CTRL;
    else                       return SRC_NONE;
  endfunction

  function automatic logic is_ram_wr(input logic [7:0] c);
    return c[7:5] == 3'b100;
  endfunction

endpackage

// File: rtl/rtcser_ram.sv
module rtcser_ram #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/rtcser_seq.sv
module rtcser_seq
  import rtcser_pkg::*;
#(
  parameter int SEL_BIT = 0,
  parameter int CLK_BIT = 1,
  parameter int DAT_BIT = 2,
  parameter int BITS    = 8,
  localparam int PH_W   = $clog2(2 * BITS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [BITS-1:0] wdata,
  input  logic [BITS-1:0] src_byte,
  output logic [BITS-1:0] cmd_o,
  output logic [BITS-1:0] ctl_o,
  output logic [BITS-1:0] rd_bits_o,
  output logic            commit_o,
  output logic [BITS-1:0] commit_cmd_o,
  output logic [BITS-1:0] commit_val_o
);

  localparam logic [PH_W-1:0] LAST_PH = PH_W'(2 * BITS - 1);

  logic            idle_q;
  logic [PH_W-1:0] phase_q;
  logic [BITS-1:0] cmd_q, val_q, ctl_q, rdb_q;

  logic            fall, sel, edge_ok, in_data, rd_act, host_bit, drv_bit, line_bit;
  logic [PH_W-1:0] cur_ph;
  logic [BITS-1:0] nxt_val, ctl_nxt;
  src_e            src;

  always_comb begin
    sel      = wdata[SEL_BIT];
    fall     = ctl_q[CLK_BIT] & ~wdata[CLK_BIT];
    edge_ok  = wr & sel & fall;
    cur_ph   = idle_q ? '0 : phase_q;
    in_data  = cur_ph[PH_W-1];
    src      = decode_src(cmd_q);
    rd_act   = in_data && (src != SRC_NONE);
    host_bit = wdata[DAT_BIT];
    drv_bit  = src_byte[(BITS-1) - int'(cur_ph[PH_W-2:0])];
    line_bit = rd_act ? drv_bit : host_bit;
    nxt_val  = {val_q[BITS-2:0], line_bit};
    ctl_nxt  = wdata;
    if (edge_ok && rd_act) ctl_nxt[DAT_BIT] = drv_bit;
  end

  assign commit_o     = edge_ok && (cur_ph == LAST_PH);
  assign commit_cmd_o = cmd_q;
  assign commit_val_o = nxt_val;
  assign cmd_o        = cmd_q;
  assign ctl_o        = ctl_q;
  assign rd_bits_o    = rdb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q  <= 1'b1;
      phase_q <= '0;
      cmd_q   <= '0;
      val_q   <= '0;
      ctl_q   <= '0;
      rdb_q   <= '0;
    end else if (wr) begin
      ctl_q <= ctl_nxt;
      if (!sel) begin
        idle_q  <= 1'b1;
        phase_q <= '0;
      end else if (fall) begin
        if (!in_data) cmd_q <= {cmd_q[BITS-2:0], host_bit};
        else          val_q <= nxt_val;
        if (rd_act)   rdb_q <= {rdb_q[BITS-2:0], drv_bit};
        if (cur_ph == LAST_PH) begin
          idle_q  <= 1'b1;
          phase_q <= '0;
        end else begin
          idle_q  <= 1'b0;
          phase_q <= cur_ph + 1'b1;
        end
      end
    end
  end

  // R11: after the last data edge the sequencer is idle
  p_commit_idles_r11: assert property (@(posedge clk) disable iff (rst)
    commit_o |=> idle_q);
  // R10: deselect forces idle
  p_desel_idles_r10: assert property (@(posedge clk) disable iff (rst)
    (wr && !wdata[SEL_BIT]) |=> idle_q);
  // R2: command register moves only on a selected falling clock
  p_cmd_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
    !edge_ok |=> $stable(cmd_q));
  // R12: read-back register moves only while a read command drives the line
  p_rdb_read_only_r12: assert property (@(posedge clk) disable iff (rst)
    !(edge_ok && rd_act) |=> $stable(rdb_q));

endmodule

// File: rtl/rtcser_regs.sv
module rtcser_regs
  import rtcser_pkg::*;
#(
  parameter int          NUM_TIME   = 6,
  parameter int          RAM_DEPTH  = 32,
  parameter int          CLR_BIT    = 2,
  parameter logic [7:0]  STATUS_RST = 8'h90,
  localparam int         TIDX_W     = $clog2(NUM_TIME),
  localparam int         AW         = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        cmd,
  input  logic              commit,
  input  logic [7:0]        commit_cmd,
  input  logic [7:0]        commit_val,
  input  logic              tm_ld,
  input  logic [TIDX_W-1:0] tm_idx,
  input  logic [7:0]        tm_bcd,
  input  logic              evt,
  input  logic [7:0]        ram_q,
  output logic              ram_we,
  output logic [AW-1:0]     ram_wa,
  output logic [AW-1:0]     ram_ra,
  output logic [7:0]        src_byte,
  output logic              irq
);

  logic [7:0] tm_q [NUM_TIME];
  logic [7:0] stat_q, ctrl_q, stat_nxt, tsel;
  logic       irq_q, irq_nxt, ctrl_wr, clr;

  for (genvar g = 0; g < NUM_TIME; g++) begin : g_time
    always_ff @(posedge clk) begin
      if (rst)                                     tm_q[g] <= '0;
      else if (tm_ld && tm_idx == TIDX_W'(g))      tm_q[g] <= tm_bcd;
    end
  end

  always_comb begin
    tsel = '0;
    for (int i = 0; i < NUM_TIME; i++)
      if (int'(cmd[3:0]) == i) tsel = tm_q[i];
  end

  always_comb begin
    unique case (decode_src(cmd))
      SRC_RAM:  src_byte = ram_q;
      SRC_TIME: src_byte = tsel;
      SRC_STAT: src_byte = stat_q;
      SRC_CTRL: src_byte = ctrl_q;
      default:  src_byte = '0;
    endcase
  end

  assign ram_we = commit && is_ram_wr(commit_cmd);
  assign ram_wa = commit_cmd[AW-1:0];
  assign ram_ra = cmd[AW-1:0];

  always_comb begin
    ctrl_wr  = commit && (commit_cmd == CMD_CTRL_WR);
    clr      = ctrl_wr && commit_val[CLR_BIT];
    stat_nxt = stat_q;
    irq_nxt  = irq_q;
    if (clr) begin
      stat_nxt = stat_nxt & ~STAT_CLR_MASK;
      irq_nxt  = 1'b0;
    end
    if (evt) begin
      stat_nxt = stat_nxt | STAT_ALARM;
      irq_nxt  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= STATUS_RST;
      ctrl_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_nxt;
      irq_q  <= irq_nxt;
      if (ctrl_wr) ctrl_q <= commit_val;
    end
  end

  assign irq = irq_q;

  // R9: an alarm always wins over a simultaneous clear
  p_evt_wins_r9: assert property (@(posedge clk) disable iff (rst)
    evt |=> irq_q);
  // R8: a clearing control write without alarm drops the interrupt
  p_clr_drops_irq_r8: assert property (@(posedge clk) disable iff (rst)
    (commit && commit_cmd == CMD_CTRL_WR && commit_val[CLR_BIT] && !evt) |=> !irq_q);
  // R8: interrupt mirrors the alarm status bit
  p_irq_tracks_stat_r8: assert property (@(posedge clk) disable iff (rst)
    irq_q == stat_q[3]);
  // R6: control byte changes only through a 0xB1 commit
  p_ctrl_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(commit && commit_cmd == CMD_CTRL_WR) |=> $stable(ctrl_q));

endmodule

// File: rtl/rtcser_top.sv
module rtcser_top #(
  parameter int         RAM_DEPTH  = 32,
  parameter int         NUM_TIME   = 6,
  parameter int         SEL_BIT    = 0,
  parameter int         CLK_BIT    = 1,
  parameter int         DAT_BIT    = 2,
  parameter logic [7:0] STATUS_RST = 8'h90,
  localparam int        TIDX_W     = $clog2(NUM_TIME),
  localparam int        AW         = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_wdata,
  output logic [7:0]        ctl_rdata,
  input  logic              tm_ld,
  input  logic [TIDX_W-1:0] tm_idx,
  input  logic [7:0]        tm_bcd,
  input  logic              alarm_evt,
  output logic              rtc_irq,
  output logic [7:0]        rd_bits
);

  logic [7:0]    cmd, src_byte, commit_cmd, commit_val, ram_q;
  logic          commit, ram_we;
  logic [AW-1:0] ram_wa, ram_ra;

  rtcser_seq #(
    .SEL_BIT(SEL_BIT), .CLK_BIT(CLK_BIT), .DAT_BIT(DAT_BIT), .BITS(8)
  ) u_seq (
    .clk(clk), .rst(rst), .wr(ctl_wr), .wdata(ctl_wdata), .src_byte(src_byte),
    .cmd_o(cmd), .ctl_o(ctl_rdata), .rd_bits_o(rd_bits), .commit_o(commit),
    .commit_cmd_o(commit_cmd), .commit_val_o(commit_val)
  );

  rtcser_regs #(
    .NUM_TIME(NUM_TIME), .RAM_DEPTH(RAM_DEPTH), .CLR_BIT(2), .STATUS_RST(STATUS_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .cmd(cmd), .commit(commit), .commit_cmd(commit_cmd),
    .commit_val(commit_val), .tm_ld(tm_ld), .tm_idx(tm_idx), .tm_bcd(tm_bcd),
    .evt(alarm_evt), .ram_q(ram_q), .ram_we(ram_we), .ram_wa(ram_wa),
    .ram_ra(ram_ra), .src_byte(src_byte), .irq(rtc_irq)
  );

  rtcser_ram #(.DEPTH(RAM_DEPTH), .WIDTH(8)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_wa), .wdata(commit_val),
    .raddr(ram_ra), .rdata(ram_q)
  );

endmodule

// File: tb/rtcser_top_tb_top.sv
module rtcser_top_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic       tm_ld = 1'b0;
  logic [2:0] tm_idx = 3'd0;
  logic [7:0] tm_bcd = 8'h00;
  logic       alarm_evt = 1'b0;
  logic       rtc_irq;
  logic [7:0] rd_bits;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  rtcser_top dut_i (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .tm_ld(tm_ld), .tm_idx(tm_idx), .tm_bcd(tm_bcd),
    .alarm_evt(alarm_evt), .rtc_irq(rtc_irq), .rd_bits(rd_bits)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_ram [32];
  logic [7:0] m_tm [6];
  logic [7:0] m_stat, m_ctrl, m_cmd, m_val, m_ctl, m_rdb;
  logic       m_irq, m_idle;
  int         m_ph;

  function automatic int msrc(input logic [7:0] c);
    if (c < 8'h20) return int'(m_ram[c[4:0]]);
    if (c < 8'h30) return (c - 8'h20 < 6) ? int'(m_tm[c - 8'h20]) : 0;
    if (c == 8'h30) return int'(m_stat);
    if (c == 8'h31) return int'(m_ctrl);
    return -1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_stat = 8'h90; m_ctrl = 0; m_cmd = 0; m_val = 0; m_ctl = 0; m_rdb = 0;
      m_irq = 0; m_idle = 1; m_ph = 0;
      for (int i = 0; i < 6; i++) m_tm[i] = 0;
    end else begin
      logic [7:0] b;
      bit do_commit;
      do_commit = 0;
      if (ctl_wr) begin
        b = ctl_wdata;
        if (!b[0]) m_idle = 1;
        else if (m_ctl[1] && !b[1]) begin
          int p;
          p = m_idle ? 0 : m_ph;
          if (p < 8) m_cmd = {m_cmd[6:0], b[2]};
          else begin
            int s;
            s = msrc(m_cmd);
            if (s >= 0) begin
              b[2] = s[15 - p];
              m_rdb = {m_rdb[6:0], b[2]};
            end
            m_val = {m_val[6:0], b[2]};
          end
          if (p == 15) begin do_commit = 1; m_idle = 1; end
          else begin m_ph = p + 1; m_idle = 0; end
        end
        m_ctl = b;
      end
      if (do_commit) begin
        if (m_cmd >= 8'h80 && m_cmd <= 8'h9F) m_ram[m_cmd[4:0]] = m_val;
        if (m_cmd == 8'hB1) begin
          m_ctrl = m_val;
          if (m_val[2]) begin m_stat = m_stat & ~8'h18; m_irq = 0; end
        end
      end
      if (alarm_evt) begin m_stat = m_stat | 8'h08; m_irq = 1; end
      if (tm_ld && tm_idx < 6) m_tm[tm_idx] = tm_bcd;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (!rst && !done) begin
      vectors++;
      if (ctl_rdata !== m_ctl || rtc_irq !== m_irq || rd_bits !== m_rdb) begin
        errors++;
        $display("FAIL R4/R8 per-cycle: actual ctl=%02h irq=%0b rdb=%02h expected ctl=%02h irq=%0b rdb=%02h",
                 ctl_rdata, rtc_irq, rd_bits, m_ctl, m_irq, m_rdb);
      end
    end
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input bit evt = 0);
    ctl_wr = 1; ctl_wdata = b; alarm_evt = evt;
    @(negedge clk);
    ctl_wr = 0; alarm_evt = 0;
  endtask

  task automatic xfer(input logic [7:0] c, input logic [7:0] d, input int nbits,
                      input bit evt_last = 0, input bit noisy = 0);
    for (int i = 0; i < nbits; i++) begin
      logic bt;
      bt = (i < 8) ? c[7 - i] : d[15 - i];
      put({5'b0, bt, 2'b11});
      if (noisy) put({5'b0, bt, 2'b11});
      put({5'b0, bt, 2'b01}, evt_last && (i == nbits - 1));
      if (noisy) put({5'b0, bt, 2'b01});
    end
  endtask

  task automatic rd(input logic [7:0] c, input string tag, input logic [7:0] exp);
    xfer(c, 8'h00, 16);
    chk(tag, rd_bits, exp);
    put(8'h00);
  endtask

  task automatic wrt(input logic [7:0] c, input logic [7:0] d);
    xfer(c, d, 16);
    put(8'h00);
  endtask

  task automatic load_tm(input int idx, input logic [7:0] v);
    tm_ld = 1; tm_idx = 3'(idx); tm_bcd = v;
    @(negedge clk);
    tm_ld = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1 ctl", ctl_rdata, 8'h00);
    chk("R1 irq", {7'b0, rtc_irq}, 8'h00);
    chk("R1 rdbits", rd_bits, 8'h00);
    // R5 / R1: status after reset
    rd(8'h30, "R5 status reset", 8'h90);

    // R3: RAM write and read back
    wrt(8'h85, 8'hA5);
    rd(8'h05, "R3 ram[5]", 8'hA5);
    wrt(8'h9F, 8'h3C);
    rd(8'h1F, "R3 ram[31]", 8'h3C);

    // R4: driven bit appears on bit 2 at the last edge (LSB of 0xA5 is 1)
    xfer(8'h05, 8'h00, 16);
    chk("R4 line bit", ctl_rdata, 8'h05);
    put(8'h00);

    // R12: write command keeps host data bit, read-back unchanged
    xfer(8'h86, 8'h01, 16);
    chk("R12 host bit", ctl_rdata, 8'h05);
    chk("R12 rdbits held", rd_bits, 8'hA5);
    put(8'h00);
    xfer(8'h86, 8'h00, 16);
    chk("R12 host bit low", ctl_rdata, 8'h01);
    put(8'h00);

    // R2: steady-clock writes do not advance the transfer
    xfer(8'h8A, 8'h5E, 16, 0, 1);
    put(8'h00);
    rd(8'h0A, "R2 noisy write", 8'h5E);

    // R10: aborted transfer is not committed, next starts at phase 0
    wrt(8'h82, 8'h11);
    xfer(8'h82, 8'hFF, 12);
    put(8'h00);
    rd(8'h02, "R10 abort keeps", 8'h11);
    xfer(8'h82, 8'hFF, 5);
    put(8'h00);
    wrt(8'h81, 8'h77);
    rd(8'h01, "R10 restart", 8'h77);

    // R11: back-to-back transfers without deselect
    xfer(8'h83, 8'h5A, 16);
    xfer(8'h03, 8'h00, 16);
    chk("R11 back-to-back", rd_bits, 8'h5A);
    put(8'h00);

    // R7: time registers
    load_tm(0, 8'h59); load_tm(1, 8'h42); load_tm(2, 8'h23);
    load_tm(3, 8'h31); load_tm(4, 8'h12); load_tm(5, 8'h24);
    rd(8'h20, "R7 seconds", 8'h59);
    rd(8'h22, "R7 hours", 8'h23);
    rd(8'h25, "R7 year", 8'h24);
    rd(8'h26, "R7 unused 0x26", 8'h00);
    rd(8'h2F, "R7 unused 0x2F", 8'h00);

    // R6: control write without clear bit
    wrt(8'hB1, 8'h41);
    rd(8'h31, "R6 control", 8'h41);
    rd(8'h30, "R6 status kept", 8'h90);

    // R8: alarm sets, non-clearing write keeps, clearing write drops
    put(8'h00, 1);
    chk("R8 irq set", {7'b0, rtc_irq}, 8'h01);
    rd(8'h30, "R8 status alarm", 8'h98);
    wrt(8'hB1, 8'h40);
    chk("R8 irq kept", {7'b0, rtc_irq}, 8'h01);
    wrt(8'hB1, 8'h44);
    chk("R8 irq cleared", {7'b0, rtc_irq}, 8'h00);
    rd(8'h30, "R8 status cleared", 8'h80);

    // R9: alarm and clear in the same clock
    xfer(8'hB1, 8'h04, 16, 1);
    chk("R9 irq stays", {7'b0, rtc_irq}, 8'h01);
    put(8'h00);
    rd(8'h30, "R9 status", 8'h88);

    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule